// File: doc/BRIEF.md
# Firmware Hub Write-Cycle Target

This block sits on the memory-device side of a 4-bit multiplexed firmware-hub bus. It watches an active-low frame strobe and the nibble-wide bus, and follows each write cycle nibble by nibble. A cycle opens with a start code. A device-select nibble must then match the strap pins. Seven address nibbles, a size nibble and two data nibbles follow. When the cycle is complete and legal, the block hands the captured byte and its 28-bit address to the flash logic behind it as a one-clock strobe.

After the host's two-clock turnaround, the block takes over the shared bus. It acknowledges the byte with a ready sync, drives an all-ones turnaround nibble, and then releases the bus to the host. The bus is modelled as a separate input nibble, output nibble and output enable, which the pad ring combines into the bidirectional pins. An asynchronous active-low reset is released through a two-stage synchroniser, so the block responds two clocks after `rst_n` rises.

Top module: `fwhub_wr_target`

## Requirements
- R1: While reset is held and after it is released, `bus_oe` and `wr_valid` are low until a legal cycle completes.
- R2: A cycle starts only from the nibble sampled on the last rising edge with `frame_n` low, and only if that nibble is 1110b. An earlier 1110b followed by another value while the strobe stays low does not start a cycle. Bus values seen with `frame_n` high while idle are ignored.
- R3: The nibble on the first edge with `frame_n` high after a start is the device select. If it differs from `dev_strap`, the rest of the cycle produces no strobe and no bus drive.
- R4: The next seven nibbles form `wr_addr`, most significant nibble first: the first supplies bits 27:24 and the seventh supplies bits 3:0.
- R5: The nibble after the address is the size. Only 0000b is accepted. Any other value ends the cycle with no strobe and no bus drive.
- R6: The next two nibbles form `wr_data`: the first gives bits 3:0 and the second gives bits 7:4.
- R7: `wr_valid` is high for exactly one clock, the clock after the edge that samples the high data nibble. `wr_addr` and `wr_data` are valid in that clock.
- R8: Counting the start edge as edge 1, `bus_oe` is high for exactly the three clocks after edges 13, 14 and 15. In those clocks `bus_out` carries 1111b, then 0000b (ready sync), then 1111b.
- R9: `bus_oe` is low again after edge 16, and a new start code can begin the next cycle directly after edge 17.
- R10: `frame_n` sampled low at any point of a cycle aborts it: `bus_oe` is low on the next clock, no later strobe of that cycle occurs, and the nibble sampled on that edge is evaluated as a start code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all fields are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Nibble currently present on the shared bus |
| dev_strap | input | 4 | Strap value this device answers to |
| bus_out | output | 4 | Nibble the block drives while it owns the bus |
| bus_oe | output | 1 | Output enable for the bus pads |
| wr_valid | output | 1 | One-clock strobe marking a received byte |
| wr_addr | output | ADDR_W (28) | Address of the received byte |
| wr_data | output | 8 | Received data byte |

## Verification
The write cycle is exercised with matching and non-matching selects, legal and illegal sizes, and several strobe-low nibbles ahead of the real start. These patterns tell last-start recognition apart from first-start recognition, and select rejection apart from size rejection. Directed cycles with all-ones and alternating address and data patterns expose nibble-order and bit-lane swaps. A seeded random mix of addresses, data, select values and abort points follows. Aborts placed before the data, inside the host turnaround and inside the target-driven clocks separate a correct release of the bus from a late one or a spurious strobe. Back-to-back cycles with no gap show that the block is idle again in time for the next start.

// File: rtl/fwhub_pkg.sv
package fwhub_pkg;
  localparam int NIB_W = 4;
  localparam int BYTE_W = 8;

  localparam logic [NIB_W-1:0] START_WR = 4'b1110;
  localparam logic [NIB_W-1:0] SIZE_ONE = 4'b0000;
  localparam logic [NIB_W-1:0] SYNC_RDY = 4'b0000;
  localparam logic [NIB_W-1:0] TURN_NIB = 4'b1111;

  // States are named after the bus field occupying the clock that follows
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARMED,   // start code seen, select nibble next
    ST_ADDR,
    ST_SIZE,
    ST_DLO,
    ST_DHI,
    ST_HTAR0,   // host drives ones
    ST_HTAR1,   // target picks up bus
    ST_SYNC,    // ready sync
    ST_TTAR0,   // target drives ones
    ST_TTAR1    // target floats
  } fwh_state_e;
endpackage

// File: rtl/fwhub_seq.sv
module fwhub_seq
  import fwhub_pkg::*;
#(
  parameter int ADDR_NIBS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] bus_in,
  input  logic [NIB_W-1:0] dev_strap,
  output fwh_state_e       state_q,
  output logic             shift_addr,
  output logic             take_lo,
  output logic             take_hi
);
  localparam int CNT_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

  fwh_state_e       state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!frame_n) begin
      // any low strobe re-evaluates the start code, aborting a cycle in flight
      state_d = (bus_in == START_WR) ? ST_ARMED : ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_IDLE;
        ST_ARMED: state_d = (bus_in == dev_strap) ? ST_ADDR : ST_IDLE;
        ST_ADDR: begin
          if (cnt_q == CNT_LAST) begin
            state_d = ST_SIZE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SIZE:  state_d = (bus_in == SIZE_ONE) ? ST_DLO : ST_IDLE;
        ST_DLO:   state_d = ST_DHI;
        ST_DHI:   state_d = ST_HTAR0;
        ST_HTAR0: state_d = ST_HTAR1;
        ST_HTAR1: state_d = ST_SYNC;
        ST_SYNC:  state_d = ST_TTAR0;
        ST_TTAR0: state_d = ST_TTAR1;
        ST_TTAR1: state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign shift_addr = frame_n && (state_q == ST_ADDR);
  assign take_lo    = frame_n && (state_q == ST_DLO);
  assign take_hi    = frame_n && (state_q == ST_DHI);

  p_sel_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && state_q == ST_ARMED && bus_in != dev_strap) |=> state_q == ST_IDLE);

  p_size_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && state_q == ST_SIZE && bus_in != SIZE_ONE) |=> state_q == ST_IDLE);
endmodule

// File: rtl/fwhub_collect.sv
module fwhub_collect
  import fwhub_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  bus_in,
  input  logic              shift_addr,
  input  logic              take_lo,
  input  logic              take_hi,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [NIB_W-1:0]  lo_q, lo_d;
  logic [ADDR_W-1:0] wr_addr_d;
  logic [BYTE_W-1:0] wr_data_d;

  always_comb begin
    addr_d    = shift_addr ? {addr_q[ADDR_W-NIB_W-1:0], bus_in} : addr_q;
    lo_d      = take_lo ? bus_in : lo_q;
    wr_addr_d = take_hi ? addr_q : wr_addr;
    wr_data_d = take_hi ? {bus_in, lo_q} : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      lo_q     <= '0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_valid <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      lo_q     <= lo_d;
      wr_addr  <= wr_addr_d;
      wr_data  <= wr_data_d;
      wr_valid <= take_hi;
    end
  end

  p_one_clock_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
endmodule

// File: rtl/fwhub_bus_drv.sv
module fwhub_bus_drv
  import fwhub_pkg::*;
(
  input  fwh_state_e       state_q,
  output logic [NIB_W-1:0] bus_out,
  output logic             bus_oe
);
  always_comb begin
    bus_oe  = 1'b0;
    bus_out = TURN_NIB;
    unique case (state_q)
      ST_HTAR1: begin bus_oe = 1'b1; bus_out = TURN_NIB; end
      ST_SYNC:  begin bus_oe = 1'b1; bus_out = SYNC_RDY; end
      ST_TTAR0: begin bus_oe = 1'b1; bus_out = TURN_NIB; end
      default:  begin bus_oe = 1'b0; bus_out = TURN_NIB; end
    endcase
  end
endmodule

// File: rtl/fwhub_wr_target.sv
module fwhub_wr_target
  import fwhub_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        bus_in,
  input  logic [3:0]        dev_strap,
  output logic [3:0]        bus_out,
  output logic              bus_oe,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int ADDR_NIBS = ADDR_W / NIB_W;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  fwh_state_e state_q;
  logic       shift_addr, take_lo, take_hi;

  fwhub_seq #(.ADDR_NIBS(ADDR_NIBS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame_n    (frame_n),
    .bus_in     (bus_in),
    .dev_strap  (dev_strap),
    .state_q    (state_q),
    .shift_addr (shift_addr),
    .take_lo    (take_lo),
    .take_hi    (take_hi)
  );

  fwhub_collect #(.ADDR_W(ADDR_W)) u_collect (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_in     (bus_in),
    .shift_addr (shift_addr),
    .take_lo    (take_lo),
    .take_hi    (take_hi),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  fwhub_bus_drv u_drv (
    .state_q (state_q),
    .bus_out (bus_out),
    .bus_oe  (bus_oe)
  );

  p_no_drive_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !frame_n |=> !bus_oe);

  p_drive_follows_byte_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(bus_oe) |-> $past(wr_valid));

  p_release_after_three_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($fell(bus_oe) && $past(frame_n)) |-> $past(bus_oe, 3));
endmodule

// File: tb/fwhub_wr_target_tb.sv
module fwhub_wr_target_tb;
  localparam int ADDR_W = 28;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              frame_n;
  logic [3:0]        host_nib;
  logic [3:0]        bus_in;
  logic [3:0]        dev_strap;
  logic [3:0]        bus_out;
  logic              bus_oe;
  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  // host side of the shared pins; a floating host reads as all ones
  assign bus_in = bus_oe ? bus_out : host_nib;

  fwhub_wr_target #(.ADDR_W(ADDR_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .bus_in    (bus_in),
    .dev_strap (dev_strap),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one bus clock: drive at the falling edge, sample after the next rising edge
  task automatic tick(input logic f, input logic [3:0] n);
    frame_n  = f;
    host_nib = n;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] field_nib(input int c, input logic [3:0] st,
      input logic [3:0] sel, input logic [27:0] addr, input logic [3:0] size,
      input logic [7:0] data);
    if (c == 1) return st;
    if (c == 2) return sel;
    if (c >= 3 && c <= 9) return addr[4*(9-c) +: 4];   // R4 MS nibble first
    if (c == 10) return size;
    if (c == 11) return data[3:0];                     // R6 low nibble first
    if (c == 12) return data[7:4];
    return 4'hF;
  endfunction

  function automatic logic exp_valid(input int c, input logic ok, input int abort_at);
    return ok && (c == 12) && (abort_at == 0 || abort_at > 12);
  endfunction

  function automatic logic exp_oe(input int c, input logic ok, input int abort_at);
    return ok && (c >= 13) && (c <= 15) && (abort_at == 0 || c < abort_at);
  endfunction

  function automatic logic [3:0] exp_drv(input int c);
    return (c == 14) ? 4'h0 : 4'hF;
  endfunction

  task automatic run_cycle(input string tag, input int pre, input logic [3:0] pre_nib,
      input logic [3:0] last_st, input logic [3:0] sel, input logic [27:0] addr,
      input logic [3:0] size, input logic [7:0] data, input int abort_at, input int gap);
    logic       ok;
    logic       f;
    logic [3:0] nib;
    ok = (last_st == 4'hE) && (sel == dev_strap) && (size == 4'h0);
    for (int k = 0; k < pre; k++) tick(1'b0, pre_nib);
    for (int c = 1; c <= 17; c++) begin
      f   = (c != 1);
      nib = field_nib(c, last_st, sel, addr, size, data);
      if (c == abort_at) begin
        f   = 1'b0;
        nib = 4'hE;
      end
      tick(f, nib);
      chk($sformatf("%s R7 strobe clk%0d", tag, c), 32'(wr_valid), 32'(exp_valid(c, ok, abort_at)));
      if (exp_valid(c, ok, abort_at)) begin
        chk($sformatf("%s R4 address", tag), 32'(wr_addr), 32'(addr));
        chk($sformatf("%s R6 data", tag), 32'(wr_data), 32'(data));
      end
      chk($sformatf("%s R8 enable clk%0d", tag, c), 32'(bus_oe), 32'(exp_oe(c, ok, abort_at)));
      if (exp_oe(c, ok, abort_at))
        chk($sformatf("%s R8 drive clk%0d", tag, c), 32'(bus_out), 32'(exp_drv(c)));
      if (c == abort_at) break;
    end
    for (int g = 0; g < gap; g++) begin
      tick(1'b1, 4'($urandom_range(0, 15)));
      chk($sformatf("%s R2 idle ignore", tag), 32'({bus_oe, wr_valid}), 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n     = 1'b0;
    frame_n   = 1'b1;
    host_nib  = 4'hF;
    dev_strap = 4'h5;
    repeat (3) @(negedge clk);
    chk("R1 reset oe", 32'(bus_oe), 32'h0);
    chk("R1 reset strobe", 32'(wr_valid), 32'h0);
    rst_n = 1'b1;
    repeat (4) tick(1'b1, 4'hE);
    chk("R1 idle after release", 32'({bus_oe, wr_valid}), 32'h0);

    // basic cycle then back-to-back with no gap (R9)
    run_cycle("R2 basic", 0, 4'h0, 4'hE, 4'h5, 28'h1234567, 4'h0, 8'hA5, 0, 0);
    run_cycle("R9 back-to-back", 0, 4'h0, 4'hE, 4'h5, 28'hFFFFFFF, 4'h0, 8'hFF, 0, 2);
    run_cycle("R4 pattern", 0, 4'h0, 4'hE, 4'h5, 28'hA5C3E1F, 4'h0, 8'h3C, 0, 1);
    // last start nibble counts (R2)
    run_cycle("R2 late start", 3, 4'h2, 4'hE, 4'h5, 28'h0000001, 4'h0, 8'h01, 0, 1);
    run_cycle("R2 start overwritten", 2, 4'hE, 4'h6, 4'h5, 28'h0ABCDEF, 4'h0, 8'h10, 0, 1);
    // select and size rejection
    run_cycle("R3 mismatch", 0, 4'h0, 4'hE, 4'hA, 28'h7654321, 4'h0, 8'h55, 0, 1);
    run_cycle("R5 bad size", 0, 4'h0, 4'hE, 4'h5, 28'h1111111, 4'h1, 8'h66, 0, 1);
    // aborts: before data, in host turnaround, during target drive
    run_cycle("R10 abort addr", 0, 4'h0, 4'hE, 4'h5, 28'h2222222, 4'h0, 8'h77, 7, 0);
    run_cycle("R10 restart", 0, 4'h0, 4'hE, 4'h5, 28'h3333333, 4'h0, 8'h88, 13, 0);
    run_cycle("R10 abort drive", 0, 4'h0, 4'hE, 4'h5, 28'h4444444, 4'h0, 8'h99, 15, 0);
    run_cycle("R10 after abort", 0, 4'h0, 4'hE, 4'h5, 28'h5555555, 4'h0, 8'hC3, 0, 1);
    // another strap value
    dev_strap = 4'hA;
    run_cycle("R3 new strap", 0, 4'h0, 4'hE, 4'hA, 28'h0F0F0F0, 4'h0, 8'h5A, 0, 1);
    run_cycle("R3 old strap", 0, 4'h0, 4'hE, 4'h5, 28'h0F0F0F0, 4'h0, 8'h5A, 0, 1);

    for (int i = 0; i < 60; i++) begin
      logic [3:0] sel;
      logic [3:0] size;
      int         ab;
      int         gap;
      sel  = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : dev_strap;
      size = ($urandom_range(0, 4) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      ab   = ($urandom_range(0, 5) == 0) ? int'($urandom_range(3, 16)) : 0;
      gap  = (ab != 0) ? 0 : int'($urandom_range(0, 3));
      run_cycle("R7 random", int'($urandom_range(0, 2)), 4'($urandom_range(0, 15)), 4'hE,
                sel, 28'($urandom()), size, 8'($urandom()), ab, gap);
    end

    report();
    $finish;
  end
endmodule